// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Overrun and Per-Byte Framing Status

This block receives bytes from an asynchronous serial line. Each frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. The bit rate comes from a programmable divisor and a speed-range select. The line is oversampled sixteen times per bit, and each bit is decided by a majority vote of three samples taken around its middle. Each completed byte moves into a holding register. A host reads that register and acknowledges it with a one-cycle read strobe.

The block reports two kinds of fault, and they behave differently. An overrun happens when a new byte completes while the held byte is still unread. The overrun is sticky and blocking: the receiver stops moving bytes until the host drives the receive enable low and then high again. A framing error is not sticky. It is a status bit stored with each byte, and it always describes the byte currently at the read port. Reception continues after a framing error, and toggling the enable does not change the framing bit.

Top module: `async_rx`

## Requirements
- R1: After reset, `data_valid`, `overrun` and `frame_err` are 0 and `rx_data` is 0x00.
- R2: A frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. The byte appears on `rx_data` with `data_valid` = 1 by the end of its stop bit.
- R3: The bit period is 16·(N+1) clock cycles when `fast_mode` = 1 and 64·(N+1) cycles when `fast_mode` = 0, where N is `baud_div`. For example, a 4 MHz clock with `fast_mode` = 1 and N = 25 gives a nominal 9600 baud. `data_valid` rises between 153·T+1 and 154·T+6 cycles after the falling edge of the start bit, where T = (N+1) cycles in fast mode and 4·(N+1) cycles in slow mode.
- R4: Each bit is the majority of three samples taken at oversample points 7, 8 and 9 of the bit. A disturbance shorter than one oversample interval, placed inside a data bit, does not change the received byte.
- R5: A start bit that is high again at the majority point is rejected. The receiver returns to idle and receives the next valid frame correctly.
- R6: `data_valid` is set when a byte enters the holding register and is cleared by `rd_stb`. Reading does not change `rx_data`.
- R7: When a frame completes while `data_valid` = 1, `overrun` becomes 1, the new byte is discarded, and the held byte and its `frame_err` are kept.
- R8: While `overrun` = 1, no byte enters the holding register, even after the held byte has been read.
- R9: Driving `rx_en` low and then high again clears `overrun` and restarts the receiver. `rx_data`, `data_valid` and `frame_err` are not changed by this toggle.
- R10: `frame_err` is 1 exactly when the stop bit of the byte now in the holding register was sampled low. It is reloaded with every byte that enters the holding register.
- R11: A framing error does not stop reception: the next good frame is received with `frame_err` = 0.
- R12: While `rx_en` = 0, activity on the line loads nothing into the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_en | input | 1 | Receive enable; a low-then-high cycle clears overrun |
| fast_mode | input | 1 | 1: bit period 16·(N+1) cycles; 0: bit period 64·(N+1) cycles |
| baud_div | input | 8 | Baud divisor N |
| rx_line | input | 1 | Serial input, idle high |
| rd_stb | input | 1 | One-cycle read acknowledge for the holding register |
| rx_data | output | 8 | Holding register contents |
| data_valid | output | 1 | Holding register contains an unread byte |
| frame_err | output | 1 | Stop-bit status of the byte in the holding register |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The assertions assume that `baud_div` and `fast_mode` change only while `rx_en` is low. They also assume that `rd_stb` is a single-cycle pulse. The bench follows both rules: it changes the configuration only with the receiver disabled, and it issues every read as one isolated strobe at a falling clock edge. Line stimulus is timed from the requirement formula for each divisor and mode. The deliberate faults (a short glitch, a short start pulse, a low stop bit) are placed well away from the sample points, except where they are meant to hit one of them.

// File: rtl/srx_pkg.sv
package srx_pkg;
  // Number of oversample ticks per serial bit.
  localparam int unsigned OVS = 16;
  // Tick index at which the three-sample majority vote is taken.
  localparam int unsigned VOTE_AT = 9;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/srx_tick_gen.sv
module srx_tick_gen #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hi_speed,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q, pre_n;
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic             tick_q, tick_n;
  logic             step;

  // In slow mode the divisor counter advances only once every 2**PRE_W cycles.
  assign step = hi_speed | (pre_q == {PRE_W{1'b1}});

  always_comb begin
    pre_n  = pre_q;
    cnt_n  = cnt_q;
    tick_n = 1'b0;
    if (!run) begin
      pre_n = '0;
      cnt_n = '0;
    end else begin
      pre_n = pre_q + 1'b1;
      if (step) begin
        if (cnt_q == divisor) begin
          cnt_n  = '0;
          tick_n = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      pre_q  <= pre_n;
      cnt_q  <= cnt_n;
      tick_q <= tick_n;
    end
  end

  assign tick = tick_q;

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && !(hi_speed && divisor == '0)) |=> !tick_q);
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
  import srx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              rx_pin,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              stop_bad
);
  localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] VOTE_CNT = CNT_W'(VOTE_AT);
  localparam logic [CNT_W-1:0] END_CNT  = CNT_W'(OVS - 1);

  // Input synchronizer, reset to the idle (high) line level.
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_pin};
  end
  assign rx_s = sync_q[SYNC_STAGES-1];

  rx_state_e         st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic [1:0]        win_q, win_n;
  logic              done_q, done_n;
  logic              bad_q, bad_n;
  logic              vote;

  // Majority of the two previous samples and the current one.
  assign vote = (win_q[1] & win_q[0]) | (win_q[1] & rx_s) | (win_q[0] & rx_s);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    idx_n  = idx_q;
    sh_n   = sh_q;
    win_n  = win_q;
    done_n = 1'b0;
    bad_n  = bad_q;
    if (!run) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
      idx_n = '0;
    end else if (tick) begin
      win_n = {win_q[0], rx_s};
      cnt_n = cnt_q + 1'b1;
      unique case (st_q)
        ST_IDLE: begin
          cnt_n = '0;
          if (!rx_s) begin
            st_n  = ST_START;
            cnt_n = CNT_W'(1);
          end
        end
        ST_START: begin
          if (cnt_q == VOTE_CNT && vote) st_n = ST_IDLE;
          else if (cnt_q == END_CNT) begin
            st_n  = ST_DATA;
            idx_n = '0;
          end
        end
        ST_DATA: begin
          if (cnt_q == VOTE_CNT) sh_n = {vote, sh_q[DATA_W-1:1]};
          if (cnt_q == END_CNT) begin
            if (idx_q == LAST_IDX) st_n = ST_STOP;
            else                   idx_n = idx_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt_q == VOTE_CNT) begin
            done_n = 1'b1;
            bad_n  = ~vote;
            st_n   = ST_IDLE;
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      win_q  <= '1;
      done_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      sh_q   <= sh_n;
      win_q  <= win_n;
      done_q <= done_n;
      bad_q  <= bad_n;
    end
  end

  assign done     = done_q;
  assign data     = sh_q;
  assign stop_bad = bad_q;

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R12
  halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (st_q == ST_IDLE));
endmodule

// File: rtl/srx_hold.sv
module srx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              done,
  input  logic [DATA_W-1:0] din,
  input  logic              stop_bad,
  input  logic              rd,
  output logic [DATA_W-1:0] data,
  output logic              valid,
  output logic              ferr,
  output logic              oerr
);
  logic [DATA_W-1:0] data_q, data_n;
  logic              valid_q, valid_n;
  logic              ferr_q, ferr_n;
  logic              oerr_q, oerr_n;
  logic              load, clash;

  // A read in the same cycle frees the register for the new byte.
  assign load  = done & ~oerr_q & (~valid_q | rd);
  assign clash = done & ~oerr_q & valid_q & ~rd;

  always_comb begin
    data_n  = data_q;
    valid_n = valid_q;
    ferr_n  = ferr_q;
    oerr_n  = oerr_q;
    if (load) begin
      data_n  = din;
      ferr_n  = stop_bad;
      valid_n = 1'b1;
    end else if (rd) begin
      valid_n = 1'b0;
    end
    if (!en)        oerr_n = 1'b0;
    else if (clash) oerr_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
      oerr_q  <= 1'b0;
    end else begin
      data_q  <= data_n;
      valid_q <= valid_n;
      ferr_q  <= ferr_n;
      oerr_q  <= oerr_n;
    end
  end

  assign data  = data_q;
  assign valid = valid_q;
  assign ferr  = ferr_q;
  assign oerr  = oerr_q;

  // R8
  frozen_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oerr_q |=> $stable(data_q));

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !done) |=> !valid_q);

  // R9
  ferr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !done) |=> $stable(ferr_q));
endmodule

// File: rtl/async_rx.sv
module async_rx #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              fast_mode,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              rx_line,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rx_data,
  output logic              data_valid,
  output logic              frame_err,
  output logic              overrun
);
  // Reset is asserted asynchronously and released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              run;
  logic              tick;
  logic              done;
  logic [DATA_W-1:0] frame_data;
  logic              frame_bad;
  logic              oerr;

  // The receiver stops while an overrun is pending.
  assign run = rx_en & ~oerr;

  srx_tick_gen #(.DIV_W(DIV_W), .PRE_W(2)) u_tick (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (run),
    .hi_speed (fast_mode),
    .divisor  (baud_div),
    .tick     (tick)
  );

  srx_frame_fsm #(.DATA_W(DATA_W), .SYNC_STAGES(2)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (run),
    .tick     (tick),
    .rx_pin   (rx_line),
    .done     (done),
    .data     (frame_data),
    .stop_bad (frame_bad)
  );

  srx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en       (rx_en),
    .done     (done),
    .din      (frame_data),
    .stop_bad (frame_bad),
    .rd       (rd_stb),
    .data     (rx_data),
    .valid    (data_valid),
    .ferr     (frame_err),
    .oerr     (oerr)
  );

  assign overrun = oerr;

  // R7
  overrun_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(overrun) |-> data_valid || $past(rd_stb));
endmodule

// File: tb/async_rx_bench.sv
module async_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       fast_mode = 1'b1;
  logic [7:0] baud_div = 8'd0;
  logic       rx_line = 1'b1;
  logic       rd_stb = 1'b0;
  logic [7:0] rx_data;
  logic       data_valid, frame_err, overrun;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t_start = 0;
  int t_valid = 0;
  logic prev_valid = 1'b0;
  int bit_clks = 32;
  int tick_clks = 2;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (data_valid && !prev_valid) t_valid = cyc;
    prev_valid = data_valid;
  end

  async_rx u_async_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .fast_mode(fast_mode),
    .baud_div(baud_div), .rx_line(rx_line), .rd_stb(rd_stb),
    .rx_data(rx_data), .data_valid(data_valid), .frame_err(frame_err),
    .overrun(overrun)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic configure(input logic fm, input int n);
    @(negedge clk);
    rx_en = 1'b0;
    fast_mode = fm;
    baud_div = 8'(n);
    tick_clks = fm ? (n + 1) : 4 * (n + 1);
    bit_clks = 16 * tick_clks;
    repeat (2) @(negedge clk);
    rx_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic toggle_en();
    @(negedge clk);
    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    rx_en = 1'b1;
    @(negedge clk);
  endtask

  // gbit >= 0 puts a glitch shorter than one tick in the middle of that data bit.
  task automatic send(input logic [7:0] b, input logic stop_v, input int gbit);
    @(negedge clk);
    t_start = cyc;
    for (int i = 0; i < 10; i++) begin
      logic v;
      v = (i == 0) ? 1'b0 : (i == 9) ? stop_v : b[i-1];
      rx_line = v;
      if (i - 1 == gbit) begin
        repeat (bit_clks / 2 - 1) @(negedge clk);
        rx_line = ~v;
        repeat (tick_clks - 1) @(negedge clk);
        rx_line = v;
        repeat (bit_clks - bit_clks / 2 + 1 - (tick_clks - 1)) @(negedge clk);
      end else begin
        repeat (bit_clks) @(negedge clk);
      end
    end
    rx_line = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_pulse();
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(!data_valid && !overrun && !frame_err && rx_data == 8'h00, "R1 reset",
        {data_valid, overrun, frame_err, rx_data}, 0);

    // R2 R3 R6: sweep both speed ranges and several divisors.
    for (int fm = 0; fm < 2; fm++) begin
      for (int n = 0; n < 4; n++) begin
        configure(1'(fm), n);
        for (int k = 0; k < 4; k++) begin
          logic [7:0] b;
          int lat;
          b = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((n * 37 + fm * 91 + k * 73) ^ 8'hA5);
          send(b, 1'b1, -1);
          chk(data_valid && rx_data == b && !frame_err, "R2 byte", rx_data, b);
          lat = t_valid - t_start;
          chk(lat >= 153 * tick_clks + 1 && lat <= 154 * tick_clks + 6, "R3 latency",
              lat, 153 * tick_clks);
          read_pulse();
          chk(!data_valid && rx_data == b, "R6 read clears valid", data_valid, 0);
        end
      end
    end

    // R3: 4 MHz clock, fast mode, divisor 25 -> 416 cycles per bit.
    configure(1'b1, 25);
    send(8'h55, 1'b1, -1);
    chk(data_valid && rx_data == 8'h55, "R3 divisor 25", rx_data, 8'h55);
    chk(t_valid - t_start >= 153 * 26 + 1 && t_valid - t_start <= 154 * 26 + 6,
        "R3 9600 timing", t_valid - t_start, 153 * 26);
    read_pulse();

    // R4: short glitch inside data bits.
    configure(1'b1, 3);
    for (int g = 0; g < 8; g++) begin
      logic [7:0] b;
      b = 8'(8'h3C ^ (g * 17));
      send(b, 1'b1, g);
      chk(data_valid && rx_data == b, "R4 majority vote", rx_data, b);
      read_pulse();
    end

    // R5: short start pulse is rejected, next frame is received.
    @(negedge clk);
    rx_line = 1'b0;
    repeat (3 * tick_clks) @(negedge clk);
    rx_line = 1'b1;
    repeat (2 * bit_clks) @(negedge clk);
    chk(!data_valid, "R5 false start ignored", data_valid, 0);
    send(8'h9A, 1'b1, -1);
    chk(data_valid && rx_data == 8'h9A, "R5 recovery", rx_data, 8'h9A);
    read_pulse();

    // R10 R11: a bad stop bit sets the flag; the next byte clears it.
    send(8'hC3, 1'b0, -1);
    repeat (2 * bit_clks) @(negedge clk);
    chk(data_valid && rx_data == 8'hC3 && frame_err, "R10 framing flag", frame_err, 1);
    read_pulse();
    send(8'h5A, 1'b1, -1);
    chk(data_valid && rx_data == 8'h5A && !frame_err, "R11 reception continues",
        {frame_err, rx_data}, 8'h5A);
    read_pulse();

    // R7 R8 R9: overrun handling.
    send(8'hE1, 1'b0, -1);
    repeat (2 * bit_clks) @(negedge clk);
    send(8'h1E, 1'b1, -1);
    chk(overrun && rx_data == 8'hE1 && frame_err, "R7 overrun keeps byte",
        {overrun, frame_err, rx_data}, {2'b11, 8'hE1});
    send(8'h77, 1'b1, -1);
    chk(overrun && rx_data == 8'hE1, "R7 still held", rx_data, 8'hE1);
    read_pulse();
    send(8'h66, 1'b1, -1);
    chk(!data_valid && rx_data == 8'hE1 && overrun, "R8 frozen after read",
        {data_valid, rx_data}, 8'hE1);
    toggle_en();
    chk(!overrun && frame_err && rx_data == 8'hE1 && !data_valid, "R9 toggle clears overrun",
        {overrun, frame_err, rx_data}, {2'b01, 8'hE1});
    send(8'h42, 1'b1, -1);
    chk(data_valid && rx_data == 8'h42 && !frame_err, "R9 receives after toggle", rx_data, 8'h42);
    read_pulse();

    // R12: disabled receiver ignores the line.
    @(negedge clk);
    rx_en = 1'b0;
    send(8'h81, 1'b1, -1);
    chk(!data_valid && rx_data == 8'h42, "R12 disabled", {data_valid, rx_data}, 8'h42);
    rx_en = 1'b1;
    send(8'h18, 1'b1, -1);
    chk(data_valid && rx_data == 8'h18, "R12 enabled again", rx_data, 8'h18);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule